// File: doc/BRIEF.md
# CORDIC Rotation Direction Generator

This block turns an integer angle, given in steps of 2π/N with N = 2^ANG_W, into the control word that drives a pipelined CORDIC rotator. The control word has three parts. The first is a half-turn flag. The second is a quarter-turn flag. The third is a vector of NSTEP micro-rotation directions, one for each angle atan(2^-i) with i = 1..NSTEP. The rotator has no 45° micro-rotation. The two coarse flags are exact, and they bring the residual angle into ±45°.

The directions are produced in two ways. The first SPLIT-1 directions come from exact sign-and-subtract steps, one pipeline register per step. The remaining directions use the small-angle relation atan(2^-i) ≈ 2·atan(2^-(i+1)). In that tail, the residual angle is biased and then divided by twice the smallest micro-angle in one stage. The bits of that quotient are the tail directions. No direction is ever zero, so every micro-rotation is always applied and the rotator gain stays constant.

One angle can be accepted on every clock. Each angle leaves after a fixed latency, carrying its own valid flag.

Top module: `cordic_dir_gen`

## Requirements
- R1: After reset, and until the first result emerges, vld_o, half_o, quarter_o and dir_o are all 0.
- R2: An angle captured with vld_i high at one rising edge appears with vld_o high after SPLIT+1 rising edges, counting the capture edge. An input is accepted on every cycle, and results keep the input order.
- R3: With q = (theta_i[ANG_W-1:ANG_W-2] + theta_i[ANG_W-3]) mod 4, the flags are half_o = q[1] and quarter_o = q[0]. Together they select a pre-rotation of q·90°.
- R4: dir_o[0] is 1 exactly when theta_i[ANG_W-3] is 0, which means the residual after the coarse move is non-negative.
- R5: Bit i-1 of dir_o set to 1 means +atan(2^-i), and cleared to 0 means −atan(2^-i). The sum q·N/4 + Σ ±atan(2^-i)·N/(2π) equals theta_i modulo N to within 1.25·atan(2^-NSTEP)·N/(2π) + 0.05 units for every angle.
- R6: On cycles where vld_o is low, half_o, quarter_o and dir_o keep their previous values.
- R7: The constants α_i are defined as atan(2^-i)·N/(2π)·2^GUARD rounded to the nearest integer. The residual r starts as the signed value of theta_i[ANG_W-3:0] times 2^GUARD. For i = 1..SPLIT-1, dir_o[i-1] = (r ≥ 0), and then r is reduced by α_i when that bit is 1 or increased by α_i when it is 0.
- R8: With T = NSTEP-SPLIT+1, B is formed from the residual r left after R7 as floor((r + 2^T·α_NSTEP) / (2·α_NSTEP)). B is 0 when the numerator is negative and is clamped to 2^T-1. Then dir_o[SPLIT-1+j] = bit T-1-j of B for j = 0..T-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | theta_i is valid this cycle |
| theta_i | input | ANG_W | Angle in steps of 2π/N |
| vld_o | output | 1 | Control word is valid |
| half_o | output | 1 | Apply a 180° pre-rotation |
| quarter_o | output | 1 | Apply a 90° pre-rotation |
| dir_o | output | NSTEP | Micro-rotation directions, bit i-1 for angle atan(2^-i) |

## Verification
A wrong coarse decode shows up at once on the quarter flags, SPLIT+1 cycles after the angle enters. It also shows up as a gross error in the reconstructed angle. A residual that is corrupted inside one exact step changes every later direction of that same word. The integer model catches such a fault in the exact bits or in the quotient bits, and a single wrong quotient bit moves the reconstructed angle by at least twice the smallest micro-angle. Because the stages hold no state between words, a fault is confined to the word it hits. A full sweep of all N angles therefore exposes it, and it cannot hide in later words.

// File: rtl/cordic_dir_gen.sv
module cordic_dir_gen #(
  parameter int ANG_W = 8,
  parameter int NSTEP = 8,
  parameter int SPLIT = 4,
  parameter int GUARD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [ANG_W-1:0] theta_i,
  output logic             vld_o,
  output logic             half_o,
  output logic             quarter_o,
  output logic [NSTEP-1:0] dir_o
);

  localparam int RW = ANG_W + GUARD;
  localparam int EX = SPLIT - 1;
  localparam int TL = NSTEP - SPLIT + 1;

  // atan(2^-i) in units of 2pi/N scaled by 2^GUARD, via odd power series
  function automatic int alpha_fx(int i);
    real x, x2, term, acc, scale;
    x = 1.0 / (2.0 ** i);
    x2 = x * x;
    term = x;
    acc = 0.0;
    for (int k = 0; k < 40; k++) begin
      if (k % 2 == 0) acc = acc + term / real'(2 * k + 1);
      else            acc = acc - term / real'(2 * k + 1);
      term = term * x2;
    end
    scale = (2.0 ** (ANG_W + GUARD)) / (2.0 * 3.14159265358979323846);
    return $rtoi(acc * scale + 0.5);
  endfunction

  localparam logic signed [RW:0] BIAS = (RW+1)'((2 ** TL) * alpha_fx(NSTEP));
  localparam logic [RW:0]        DIV  = (RW+1)'(2 * alpha_fx(NSTEP));
  localparam logic [RW:0]        TOPV = (RW+1)'((2 ** TL) - 1);

  if (SPLIT < 3 || SPLIT > NSTEP || GUARD < 1) begin : g_bad_cfg
    $error("cordic_dir_gen: need 3 <= SPLIT <= NSTEP and GUARD >= 1");
  end

  for (genvar s = 0; s <= EX; s++) begin : g_st
    logic signed [RW-1:0] rem, rem_n;
    logic [NSTEP-1:0]     dir, dir_n;
    logic [1:0]           quad, quad_n;
    logic                 vld, vld_n;

    if (s == 0) begin : g_in
      assign vld_n  = vld_i;
      assign quad_n = theta_i[ANG_W-1 -: 2] + {1'b0, theta_i[ANG_W-3]};
      assign rem_n  = {{2{theta_i[ANG_W-3]}}, theta_i[ANG_W-3:0], {GUARD{1'b0}}};
      assign dir_n  = '0;
    end else begin : g_cr
      localparam logic signed [RW-1:0] ANG = RW'(alpha_fx(s));
      logic pos;
      assign pos    = ~g_st[s-1].rem[RW-1];
      assign vld_n  = g_st[s-1].vld;
      assign quad_n = g_st[s-1].quad;
      assign rem_n  = pos ? g_st[s-1].rem - ANG : g_st[s-1].rem + ANG;
      assign dir_n  = g_st[s-1].dir | (NSTEP'(pos) << (s - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld  <= 1'b0;
        rem  <= '0;
        dir  <= '0;
        quad <= '0;
      end else begin
        vld <= vld_n;
        if (vld_n) begin
          rem  <= rem_n;
          dir  <= dir_n;
          quad <= quad_n;
        end
      end
    end
  end

  logic signed [RW:0] num;
  logic [RW:0]        quo;
  logic [TL-1:0]      tail;
  logic [NSTEP-1:0]   dir_f;

  assign num = {g_st[EX].rem[RW-1], g_st[EX].rem} + BIAS;

  always_comb begin
    if (num[RW]) quo = '0;
    else         quo = unsigned'(num) / DIV;
    tail  = (quo > TOPV) ? '1 : quo[TL-1:0];
    dir_f = g_st[EX].dir;
    for (int j = 0; j < TL; j++) dir_f[SPLIT-1+j] = tail[TL-1-j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o     <= 1'b0;
      half_o    <= 1'b0;
      quarter_o <= 1'b0;
      dir_o     <= '0;
    end else begin
      vld_o <= g_st[EX].vld;
      if (g_st[EX].vld) begin
        {half_o, quarter_o} <= g_st[EX].quad;
        dir_o               <= dir_f;
      end
    end
  end

endmodule

module cordic_dir_gen_chk #(
  parameter int ANG_W = 8,
  parameter int NSTEP = 8,
  parameter int SPLIT = 4,
  parameter int GUARD = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vld_i,
  input logic [ANG_W-1:0] theta_i,
  input logic             vld_o,
  input logic             half_o,
  input logic             quarter_o,
  input logic [NSTEP-1:0] dir_o
);
  localparam int LAT = SPLIT + 1;

  logic [LAT-1:0]   vsh;
  logic [ANG_W-1:0] tsh [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vsh <= '0;
    else        vsh <= {vsh[LAT-2:0], vld_i};
  end

  always_ff @(posedge clk) begin
    tsh[0] <= theta_i;
    for (int k = 1; k < LAT; k++) tsh[k] <= tsh[k-1];
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o == vsh[LAT-1]);

  a_r3_quadrant: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> {half_o, quarter_o} ==
      2'(tsh[LAT-1][ANG_W-1 -: 2] + {1'b0, tsh[LAT-1][ANG_W-3]}));

  a_r4_first_dir: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> dir_o[0] == ~tsh[LAT-1][ANG_W-3]);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> ($stable(dir_o) && $stable(half_o) && $stable(quarter_o)));

  a_r5_known: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> !$isunknown({half_o, quarter_o, dir_o}));
endmodule

bind cordic_dir_gen cordic_dir_gen_chk #(
  .ANG_W(ANG_W), .NSTEP(NSTEP), .SPLIT(SPLIT), .GUARD(GUARD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .theta_i(theta_i),
  .vld_o(vld_o), .half_o(half_o), .quarter_o(quarter_o), .dir_o(dir_o)
);

// File: tb/tb_cordic_dir_gen.sv
module tb_cordic_dir_gen;
  localparam int ANG_W = 8;
  localparam int NSTEP = 8;
  localparam int SPLIT = 4;
  localparam int GUARD = 8;
  localparam int N     = 1 << ANG_W;
  localparam int LAT   = SPLIT + 1;
  localparam int TL    = NSTEP - SPLIT + 1;
  localparam real PI   = 3.14159265358979323846;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             vld_i = 1'b0;
  logic [ANG_W-1:0] theta_i = '0;
  logic             vld_o, half_o, quarter_o;
  logic [NSTEP-1:0] dir_o;

  cordic_dir_gen #(.ANG_W(ANG_W), .NSTEP(NSTEP), .SPLIT(SPLIT), .GUARD(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .theta_i(theta_i),
    .vld_o(vld_o), .half_o(half_o), .quarter_o(quarter_o), .dir_o(dir_o));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, head = 0, tail = 0;
  bit done = 1'b0;
  int q_th [1024];
  int q_cy [1024];
  longint aq [NSTEP+1];
  real au [NSTEP+1];
  logic [NSTEP-1:0] last_dir = '0;
  logic last_h = 1'b0, last_q = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_word(input int th, input int icy);
    int q, low;
    longint r, num, b;
    logic [NSTEP-1:0] e;
    logic [NSTEP-1:0] m;
    real sum, err, tol;
    chk(cyc - icy == LAT, "R2 latency", cyc - icy, LAT);
    q = ((th >> (ANG_W - 2)) + ((th >> (ANG_W - 3)) & 1)) & 3;
    chk({half_o, quarter_o} == 2'(q), "R3 flags", {half_o, quarter_o}, q);
    chk(dir_o[0] == !((th >> (ANG_W - 3)) & 1), "R4 first direction", dir_o[0],
        !((th >> (ANG_W - 3)) & 1));
    low = th & (N / 4 - 1);
    if (low >= N / 8) low = low - N / 4;
    r = longint'(low) * (longint'(1) << GUARD);
    e = '0;
    for (int i = 1; i < SPLIT; i++) begin
      e[i-1] = (r >= 0);
      r = e[i-1] ? r - aq[i] : r + aq[i];
    end
    num = r + (longint'(1) << TL) * aq[NSTEP];
    b = (num < 0) ? 0 : num / (2 * aq[NSTEP]);
    if (b > (1 << TL) - 1) b = (1 << TL) - 1;
    for (int j = 0; j < TL; j++) e[SPLIT-1+j] = b[TL-1-j];
    m = NSTEP'((1 << (SPLIT - 1)) - 1);
    chk((dir_o & m) == (e & m), "R7 exact directions", dir_o & m, e & m);
    chk((dir_o & ~m) == (e & ~m), "R8 tail directions", dir_o & ~m, e & ~m);
    sum = real'(q) * real'(N) / 4.0;
    for (int i = 1; i <= NSTEP; i++) sum = sum + (dir_o[i-1] ? au[i] : -au[i]);
    err = sum - real'(th);
    while (err > real'(N) / 2.0) err = err - real'(N);
    while (err < -real'(N) / 2.0) err = err + real'(N);
    if (err < 0.0) err = -err;
    tol = 1.25 * au[NSTEP] + 0.05;
    chk(err <= tol, "R5 angle error x1000", $rtoi(err * 1000.0), $rtoi(tol * 1000.0));
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vld_o) begin
        if (head == tail) chk(1'b0, "R2 unexpected output", 1, 0);
        else begin
          check_word(q_th[head], q_cy[head]);
          head++;
        end
      end else begin
        chk(dir_o == last_dir && half_o == last_h && quarter_o == last_q,
            "R6 hold while idle", {half_o, quarter_o, dir_o}, {last_h, last_q, last_dir});
      end
      last_dir = dir_o;
      last_h = half_o;
      last_q = quarter_o;
    end
  end

  task automatic send(input int th);
    @(negedge clk);
    vld_i = 1'b1;
    theta_i = ANG_W'(th);
    q_th[tail] = th;
    q_cy[tail] = cyc;
    tail++;
  endtask

  task automatic idle();
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  initial begin
    for (int i = 1; i <= NSTEP; i++) begin
      au[i] = $atan(2.0 ** (-i)) * real'(N) / (2.0 * PI);
      aq[i] = longint'($floor(au[i] * (2.0 ** GUARD) + 0.5));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(vld_o == 0 && half_o == 0 && quarter_o == 0 && dir_o == '0, "R1 reset state",
        {vld_o, half_o, quarter_o, dir_o}, 0);
    for (int t = 0; t < N; t++) send(t);
    idle();
    for (int t = 0; t < 200; t++) begin
      if (t % 3 == 0) idle();
      send((t * 37 + 11) % N);
    end
    idle();
    repeat (LAT + 4) @(negedge clk);
    chk(head == tail, "R2 all results delivered", head, tail);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", head, tail);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule